// File: doc/BRIEF.md
# Dual-Mode Interval Timer

This block is a timer that a processor programs over a small register port. It counts rising edges of a 1 kHz reference square wave, so each count is one millisecond. The reference is asynchronous to the block clock. It passes through a synchroniser and an edge detector, and only a detected rising edge advances the counter. One counter serves both modes.

In encode mode the processor writes an interval and then issues a start command. The counter runs from zero. When it reaches the interval it stops and raises a sticky interrupt flag, which drives `irq`. In decode mode the processor starts and stops the counter itself, like a stopwatch, and reads back the elapsed count. A decode count that reaches all-ones holds there and sets an overflow status bit. The count can be read at any time.

Register map. Address 0, when written, is the control register: bit 0 starts, bit 1 stops, and bit 2 selects the mode (1 = decode). Address 0, when read, returns the elapsed count. Address 1 holds the interval. Address 2 is the status register: bit 0 is done, bit 1 is overflow and bit 2 is running. Writing 1 to status bit 0 or bit 1 clears that bit. Address 3 reads as zero.

Top module: `interval_timer`

## Requirements
- R1: After reset the count, the interval and the status bits read zero, and `irq` is low.
- R2: While running, the count advances by exactly one for each rising edge of `ref_in`. A level held high for many cycles adds only one count.
- R3: In encode mode with interval N ≥ 1, done (status bit 0) and `irq` set on the N-th reference edge after start. Running then clears and the count stays at N.
- R4: An interval of zero completes on the first reference edge after start, and the count reads 1.
- R5: Done stays set until a write to address 2 with bit 0 set. A status write with bit 0 clear leaves it set.
- R6: A write to address 0 with bit 0 set zeroes the count and clears done and overflow. It sets running and latches the mode from bit 2. Start takes precedence over stop in the same write.
- R7: In decode mode, `irq` never rises. After a write to address 0 with only bit 1 set, running clears and later reference edges leave the count unchanged.
- R8: In decode mode the count holds at 2^WIDTH-1 and sets overflow (status bit 1). Writing 1 to status bit 1 clears overflow.
- R9: The count can be read at address 0 while the timer runs. Status bit 2 shows whether it is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous 1 kHz reference square wave |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt, high while done is set |

## Verification
The bench targets an interval of zero, which a design that compares before incrementing would count out to a full wrap instead of completing at once. It holds the reference high for long stretches, which a level-sensitive design would count many times over. It drives the decode count to saturation, where a design without the hold would wrap back to zero and never flag overflow. It also checks that `irq` stays set through harmless status writes and reference edges after a stop, which catches a flag that clears itself and a counter that keeps running when halted.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             irq
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  logic [2:0]       sync_q;
  logic [WIDTH-1:0] cnt, ivl;
  logic             run, dec, done, ovf;

  wire tick     = sync_q[1] & ~sync_q[2];
  wire wr_ctrl  = wr_en && addr == 2'd0;
  wire wr_stat  = wr_en && addr == 2'd2;
  wire start    = wr_ctrl && wdata[0];
  wire stop     = wr_ctrl && wdata[1];
  wire [WIDTH-1:0] cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; ivl <= '0; run <= 1'b0; dec <= 1'b0; done <= 1'b0; ovf <= 1'b0;
    end else begin
      if (wr_en && addr == 2'd1) ivl <= wdata;
      if (wr_stat) begin
        if (wdata[0]) done <= 1'b0;
        if (wdata[1]) ovf  <= 1'b0;
      end
      if (start) begin
        cnt <= '0; run <= 1'b1; dec <= wdata[2]; done <= 1'b0; ovf <= 1'b0;
      end else if (stop) begin
        run <= 1'b0;
      end else if (tick && run) begin
        if (dec) begin
          if (cnt == MAXV) ovf <= 1'b1;
          else             cnt <= cnt_inc;
        end else begin
          cnt <= cnt_inc;
          if (cnt_inc >= ivl) begin
            done <= 1'b1;
            run  <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0:    rdata = cnt;
      2'd1:    rdata = ivl;
      2'd2:    rdata[2:0] = {run, ovf, done};
      default: rdata = '0;
    endcase
  end

  assign irq = done;

  AST_START_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && run && !done && !ovf));                       // R6
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt));                                   // R7
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dec && cnt == MAXV && !start) |=> cnt == MAXV);               // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !(wr_stat && wdata[0])) |=> done);                 // R5
  AST_ENC_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !dec);                                                // R3
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int W = 10;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;

  logic [W-1:0] m_cnt, m_ivl;
  logic m_run, m_dec, m_done, m_ovf;

  always #2 clk = ~clk;

  interval_timer #(.WIDTH(W)) dut (.clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [W-1:0] exp_status();
    return {{(W-3){1'b0}}, m_run, m_ovf, m_done};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    if (a == 2'd1) m_ivl = d;
    if (a == 2'd2) begin if (d[0]) m_done = 1'b0; if (d[1]) m_ovf = 1'b0; end
    if (a == 2'd0 && d[0]) begin
      m_cnt = '0; m_run = 1'b1; m_dec = d[2]; m_done = 1'b0; m_ovf = 1'b0;
    end else if (a == 2'd0 && d[1]) m_run = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(int hi);
    @(negedge clk); ref_in = 1'b1;
    repeat (hi) @(negedge clk);
    ref_in = 1'b0;
    repeat (4) @(negedge clk);
    if (m_run) begin
      if (m_dec) begin
        if (m_cnt == MAXV) m_ovf = 1'b1; else m_cnt = m_cnt + 1'b1;
      end else begin
        m_cnt = m_cnt + 1'b1;
        if (m_cnt >= m_ivl) begin m_done = 1'b1; m_run = 1'b0; end
      end
    end
  endtask

  task automatic check_all(string tag);
    logic [W-1:0] v;
    rd(2'd0, v); chk({tag, " count"}, v, m_cnt);
    rd(2'd2, v); chk({tag, " status"}, v, exp_status());
    chk({tag, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_done});
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd1234));
    m_cnt = '0; m_ivl = '0; m_run = 0; m_dec = 0; m_done = 0; m_ovf = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_all("R1");
    rd(2'd1, v); chk("R1 interval", v, '0);
    rd(2'd3, v); chk("R1 addr3", v, '0);

    // R4 zero interval completes on first edge
    wr(2'd1, '0); wr(2'd0, 3'b001);
    check_all("R4 before edge");
    pulse(3); check_all("R4");

    // R5 sticky done, harmless status write
    wr(2'd2, 3'b100); check_all("R5 harmless write");
    pulse(3); check_all("R5 edge while done");
    wr(2'd2, 3'b001); check_all("R5 cleared");

    // R2 long high level counts once; R3 interval 5; R9 running read
    wr(2'd1, 5); wr(2'd0, 3'b001);
    pulse(40); check_all("R2 long level");
    pulse(3); pulse(3); check_all("R9 mid run");
    pulse(3); pulse(3); check_all("R3 interval 5");

    // R6 start with stop bit also set: start wins, clears done
    wr(2'd0, 3'b011); check_all("R6 start over stop");
    wr(2'd0, 3'b010); check_all("R6 stop");

    // R7 decode stop freezes
    wr(2'd0, 3'b101);
    repeat (7) pulse(2);
    wr(2'd0, 3'b010); check_all("R7 after stop");
    repeat (3) pulse(2); check_all("R7 frozen");

    // R8 saturation and overflow clear
    wr(2'd0, 3'b101);
    repeat (int'(MAXV) + 3) pulse(2);
    check_all("R8 saturated");
    wr(2'd2, 3'b010); check_all("R8 ovf cleared");
    wr(2'd0, 3'b010);

    // random trials, R2 R3 R7
    for (int t = 0; t < 40; t++) begin
      int n = $urandom_range(0, 20);
      logic md = $urandom_range(0, 1) == 1;
      if (!md) wr(2'd1, W'($urandom_range(0, 15)));
      wr(2'd0, {md, 2'b01});
      for (int k = 0; k < n; k++) begin
        pulse($urandom_range(2, 6));
        if ($urandom_range(0, 9) == 0) wr(2'd0, 3'b010);
      end
      check_all(md ? "R7 random decode" : "R3 random encode");
      wr(2'd2, 3'b011);
      check_all("R5 random clear");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule